// File: doc/BRIEF.md
# Serial Debug Memory-Read Command Engine

This block is the target end of a synchronous serial debug link. The host moves data in frames of 17 bits, one bit per strobe, and each frame carries bits both ways at once. In each frame the host sends a command or an extension word, and the block sends back its answer to the frame before. The one command the block implements is a long-word memory read. A valid read command is followed by two address frames, upper half first. The block then issues a 32-bit read on a request/acknowledge memory port and returns the data as two 16-bit reply words, upper half first.

Replies always lag the host by one frame. While the memory access is outstanding, the block answers every host frame with not-ready and ignores the word in it, so the host simply keeps sending until a result comes back. The lower result word goes out in the same frame as the host's next command. A code the block does not recognise gets an illegal-command reply. A failed memory access gets a bus-error reply in both result slots.

The serial clock is modelled as a single-cycle bit strobe in the system clock domain, and consecutive strobes must be at least four clock cycles apart. On each strobe the block samples `ser_in`. The host reads `ser_out` just before each strobe.

Top module: `dbg_serial_engine`

## Requirements
- R1: After reset, `mem_req` is low, and the first reply frame is command-complete: flag bit 16 = 0 and bits 15:0 = 0xFFFF.
- R2: A frame is 17 strobes, and bits travel most-significant first in both directions. The reply sent during frame k+1 is the answer to the host word received in frame k.
- R3: In the idle state, a host word with bit 16 = 0 and bits 15:0 equal to the read code (default 0x2180) is accepted, and its answer is not-ready: bit 16 = 1, bits 15:0 = 0x0000.
- R4: In the idle state, any other host word is answered with illegal-command (bit 16 = 1, bits 15:0 = 0xFFFF). This includes the read code sent with bit 16 = 1. No memory request is made, and the following frame is decoded as a new command.
- R5: The two frames after an accepted command carry the upper and then the lower address half, and each is answered not-ready. `mem_req` rises on the clock edge after the edge that samples the last bit of the lower half, with `mem_addr` = {upper, lower}.
- R6: `mem_req` stays high with `mem_addr` unchanged until `mem_ack` or `mem_err` is sampled high, and drops on the next edge.
- R7: A host frame that completes while the read result is not yet held is answered not-ready. Its contents are ignored, including a read code.
- R8: After a successful read, the next reply is {0, data[31:16]} and the reply after that is {0, data[15:0]}. The host word in the frame carrying the upper half is ignored. The frame carrying the lower half is decoded as a new command.
- R9: After a bus error, both result replies are bus-error (bit 16 = 1, bits 15:0 = 0x0001). The block then returns to idle in the same way as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe, one per serial bit |
| ser_in | input | 1 | Serial data from host, sampled on `bit_stb` |
| ser_out | output | 1 | Serial data to host, valid before each `bit_stb` |
| mem_req | output | 1 | Memory read request, held until ack or error |
| mem_addr | output | 32 | Read address, stable while `mem_req` is high |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Read completed successfully |
| mem_err | input | 1 | Read ended in a bus error |

## Verification
Reads are driven at addresses of all zeros, all ones and random values, with memory latencies from zero cycles up to several frame lengths. This separates a result that lands before the first busy frame closes from one that needs several rounds of not-ready, and the number of not-ready replies is bounded from the latency. Bus errors are mixed in, which tells the two-slot error reply apart from the data path. Some filler words carry the read code, to show that busy-state frames are ignored. Illegal codes, including the read code sent with the host flag set, are placed directly after completed reads. This confirms that the lower result word, the illegal reply and the reset-time command-complete reply each arrive on the following command frame.

// File: rtl/dbg_serial_pkg.sv
// Shared types of the serial debug command engine.
// Assumes a single implemented command (long-word memory read).
package dbg_serial_pkg;

    // Command sequencer states, in frame order of one read.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ADDR_HI = 3'd1,
        ST_ADDR_LO = 3'd2,
        ST_BUSY    = 3'd3,
        ST_RES_LO  = 3'd4
    } eng_state_t;

endpackage

// File: rtl/dbg_frame_shifter.sv
// Frame shifter: shifts host bits in and reply bits out, MSB first, one bit
// per strobe, and reports each complete frame with a one-cycle pulse.
// Assumes strobes are at least four clocks apart, so a reply loaded two
// clocks after a frame closes is in place before the next strobe.
module dbg_frame_shifter #(
    parameter int                 FRAME_W   = 17,
    parameter logic [FRAME_W-1:0] RST_REPLY = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_stb,
    input  logic               ser_in,
    output logic               ser_out,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_word,
    output logic               frame_valid,
    output logic [FRAME_W-1:0] frame_word
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    logic [CNT_W-1:0]   bit_cnt_q;
    logic [FRAME_W-1:0] rx_sr_q;
    logic [FRAME_W-1:0] tx_sr_q;
    logic               fv_q;
    logic [FRAME_W-1:0] fw_q;
    logic [FRAME_W-1:0] rx_next;

    assign rx_next     = {rx_sr_q[FRAME_W-2:0], ser_in};
    assign ser_out     = tx_sr_q[FRAME_W-1];
    assign frame_valid = fv_q;
    assign frame_word  = fw_q;

    // Receive shift, bit count and frame-complete pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_sr_q   <= '0;
            fv_q      <= 1'b0;
            fw_q      <= '0;
        end else begin
            fv_q <= 1'b0;
            if (bit_stb) begin
                rx_sr_q <= rx_next;
                if (bit_cnt_q == LAST_BIT) begin
                    bit_cnt_q <= '0;
                    fv_q      <= 1'b1;
                    fw_q      <= rx_next;
                end else begin
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                end
            end
        end
    end

    // Transmit shift; a new reply load takes priority over shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr_q <= RST_REPLY;
        end else if (load) begin
            tx_sr_q <= load_word;
        end else if (bit_stb) begin
            tx_sr_q <= {tx_sr_q[FRAME_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/dbg_mem_port.sv
// Memory read port: raises a request on start, holds it with a stable
// address until ack or error, and keeps the outcome until consumed.
// Assumes start and consume never coincide.
module dbg_mem_port #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              consume,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              res_done,
    output logic              res_err,
    output logic [DATA_W-1:0] res_data
);
    logic              req_q;
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;
    logic              err_q;
    logic [DATA_W-1:0] data_q;

    assign mem_req  = req_q;
    assign mem_addr = addr_q;
    assign res_done = done_q;
    assign res_err  = err_q;
    assign res_data = data_q;

    // Request handshake and outcome capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            addr_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            data_q <= '0;
        end else if (start) begin
            req_q  <= 1'b1;
            addr_q <= start_addr;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (req_q && mem_ack) begin
                req_q  <= 1'b0;
                done_q <= 1'b1;
                data_q <= mem_rdata;
            end else if (req_q && mem_err) begin
                req_q <= 1'b0;
                err_q <= 1'b1;
            end else if (consume) begin
                done_q <= 1'b0;
                err_q  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dbg_cmd_engine.sv
// Command sequencer: decodes each received frame by state and registers
// the reply for the following frame. Starts the memory read when the low
// address word arrives and turns the outcome into two reply words.
// Assumes at most one frame_valid pulse per four clocks.
module dbg_cmd_engine
    import dbg_serial_pkg::*;
#(
    parameter int                WORD_W    = 16,
    parameter logic [WORD_W-1:0] READ_CODE = 16'h2180
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_valid,
    input  logic [WORD_W:0]     frame_word,
    output logic                reply_load,
    output logic [WORD_W:0]     reply_word,
    output logic                mem_start,
    output logic [2*WORD_W-1:0] mem_start_addr,
    output logic                res_consume,
    input  logic                res_done,
    input  logic                res_err,
    input  logic [2*WORD_W-1:0] res_data
);
    localparam int ADDR_W = 2 * WORD_W;
    localparam logic [WORD_W:0] RPL_NOT_READY = {1'b1, {WORD_W{1'b0}}};
    localparam logic [WORD_W:0] RPL_BUS_ERR   = {1'b1, {(WORD_W-1){1'b0}}, 1'b1};
    localparam logic [WORD_W:0] RPL_ILLEGAL   = {1'b1, {WORD_W{1'b1}}};
    localparam logic [WORD_W:0] RPL_CMD_DONE  = {1'b0, {WORD_W{1'b1}}};

    eng_state_t        state_q, state_d;
    logic [WORD_W-1:0] hi_q, hi_d;
    logic [WORD_W:0]   lo_q, lo_d;
    logic [WORD_W:0]   reply_q, reply_d;
    logic              load_q;
    logic              cmd_ok;

    assign cmd_ok         = !frame_word[WORD_W] && (frame_word[WORD_W-1:0] == READ_CODE);
    assign mem_start      = frame_valid && (state_q == ST_ADDR_LO);
    assign mem_start_addr = {hi_q, frame_word[WORD_W-1:0]};
    assign res_consume    = frame_valid && (state_q == ST_BUSY) && (res_done || res_err);
    assign reply_load     = load_q;
    assign reply_word     = reply_q;

    // Next state and reply for the frame just received.
    always_comb begin
        state_d = state_q;
        hi_d    = hi_q;
        lo_d    = lo_q;
        reply_d = reply_q;
        if (frame_valid) begin
            case (state_q)
                ST_IDLE: begin
                    if (cmd_ok) begin
                        state_d = ST_ADDR_HI;
                        reply_d = RPL_NOT_READY;
                    end else begin
                        reply_d = RPL_ILLEGAL;
                    end
                end
                ST_ADDR_HI: begin
                    hi_d    = frame_word[WORD_W-1:0];
                    reply_d = RPL_NOT_READY;
                    state_d = ST_ADDR_LO;
                end
                ST_ADDR_LO: begin
                    reply_d = RPL_NOT_READY;
                    state_d = ST_BUSY;
                end
                ST_BUSY: begin
                    if (res_done) begin
                        reply_d = {1'b0, res_data[ADDR_W-1:WORD_W]};
                        lo_d    = {1'b0, res_data[WORD_W-1:0]};
                        state_d = ST_RES_LO;
                    end else if (res_err) begin
                        reply_d = RPL_BUS_ERR;
                        lo_d    = RPL_BUS_ERR;
                        state_d = ST_RES_LO;
                    end else begin
                        reply_d = RPL_NOT_READY;
                    end
                end
                ST_RES_LO: begin
                    reply_d = lo_q;
                    state_d = ST_IDLE;
                end
                default: begin
                    reply_d = RPL_ILLEGAL;
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // State, address and reply registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hi_q    <= '0;
            lo_q    <= RPL_CMD_DONE;
            reply_q <= RPL_CMD_DONE;
            load_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            hi_q    <= hi_d;
            lo_q    <= lo_d;
            reply_q <= reply_d;
            load_q  <= frame_valid;
        end
    end

endmodule

// File: rtl/dbg_serial_engine.sv
// Top of the serial debug memory-read engine: frame shifter, command
// sequencer and memory port. Replies lag host frames by one frame.
// Assumes bit strobes at least four clocks apart.
module dbg_serial_engine #(
    parameter int              WORD_W    = 16,
    parameter logic [WORD_W-1:0] READ_CODE = 16'h2180
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_stb,
    input  logic                ser_in,
    output logic                ser_out,
    output logic                mem_req,
    output logic [2*WORD_W-1:0] mem_addr,
    input  logic [2*WORD_W-1:0] mem_rdata,
    input  logic                mem_ack,
    input  logic                mem_err
);
    localparam int FRAME_W = WORD_W + 1;
    localparam int ADDR_W  = 2 * WORD_W;
    localparam logic [FRAME_W-1:0] RST_REPLY = {1'b0, {WORD_W{1'b1}}};

    logic               frame_valid;
    logic [FRAME_W-1:0] frame_word;
    logic               reply_load;
    logic [FRAME_W-1:0] reply_word;
    logic               mem_start;
    logic [ADDR_W-1:0]  mem_start_addr;
    logic               res_consume;
    logic               res_done;
    logic               res_err;
    logic [ADDR_W-1:0]  res_data;

    dbg_frame_shifter #(
        .FRAME_W   (FRAME_W),
        .RST_REPLY (RST_REPLY)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb     (bit_stb),
        .ser_in      (ser_in),
        .ser_out     (ser_out),
        .load        (reply_load),
        .load_word   (reply_word),
        .frame_valid (frame_valid),
        .frame_word  (frame_word)
    );

    dbg_cmd_engine #(
        .WORD_W    (WORD_W),
        .READ_CODE (READ_CODE)
    ) u_eng (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_valid    (frame_valid),
        .frame_word     (frame_word),
        .reply_load     (reply_load),
        .reply_word     (reply_word),
        .mem_start      (mem_start),
        .mem_start_addr (mem_start_addr),
        .res_consume    (res_consume),
        .res_done       (res_done),
        .res_err        (res_err),
        .res_data       (res_data)
    );

    dbg_mem_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (ADDR_W)
    ) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (mem_start),
        .start_addr (mem_start_addr),
        .consume    (res_consume),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack),
        .mem_err    (mem_err),
        .res_done   (res_done),
        .res_err    (res_err),
        .res_data   (res_data)
    );

endmodule

// File: rtl/dbg_serial_checker.sv
// Protocol checker for the serial debug engine, bound to the top module.
// Watches the memory handshake and the frame/reply hand-off between units.
module dbg_serial_checker #(
    parameter int WORD_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mem_req,
    input logic [2*WORD_W-1:0] mem_addr,
    input logic                mem_ack,
    input logic                mem_err,
    input logic                frame_valid,
    input logic                reply_load,
    input logic [WORD_W:0]     reply_word
);
    localparam logic [WORD_W:0] ILLEGAL_W = {1'b1, {WORD_W{1'b1}}};

    // R5: a request only starts right after a frame has closed
    p_req_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(frame_valid));

    // R6: request held with stable address while unanswered
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr)));

    // R6: request released after ack or error
    p_req_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && (mem_ack || mem_err)) |=> !mem_req);

    // R4: an illegal reply never coincides with a memory access
    p_illegal_no_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_load && (reply_word == ILLEGAL_W)) |-> !mem_req);

    // R2: a frame-complete indication is a single-cycle pulse
    p_frame_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    // R2: each reply load follows a closed frame by one cycle
    p_load_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reply_load |-> $past(frame_valid));

endmodule

bind dbg_serial_engine dbg_serial_checker #(.WORD_W(WORD_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .mem_err     (mem_err),
    .frame_valid (frame_valid),
    .reply_load  (reply_load),
    .reply_word  (reply_word)
);

// File: tb/test_dbg_serial_engine.sv
`timescale 1ns/1ps
// Self-checking bench: random reads, errors and illegal codes plus directed
// corners, with replies predicted from the requirements.
module test_dbg_serial_engine;
    localparam int W  = 16;
    localparam int FW = W + 1;
    localparam logic [W-1:0]  READ  = 16'h2180;
    localparam logic [FW-1:0] NR    = 17'h10000;
    localparam logic [FW-1:0] BERR  = 17'h10001;
    localparam logic [FW-1:0] ILL   = 17'h1FFFF;
    localparam logic [FW-1:0] CDONE = 17'h0FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_stb = 1'b0;
    logic          ser_in = 1'b0;
    logic          ser_out;
    logic          mem_req;
    logic [31:0]   mem_addr;
    logic [31:0]   mem_rdata = '0;
    logic          mem_ack = 1'b0;
    logic          mem_err = 1'b0;

    int            checks = 0;
    int            errors = 0;
    bit            finished = 1'b0;
    logic [FW-1:0] exp_tail;
    int            mem_lat = 0;
    bit            mem_fail = 1'b0;
    int            wait_cnt = 0;
    int            req_cnt = 0;
    logic [31:0]   cap_addr = '0;
    logic          prev_req = 1'b0;

    always #2.5 clk = ~clk;

    dbg_serial_engine i_dbg_serial_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .ser_in    (ser_in),
        .ser_out   (ser_out),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err)
    );

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, a[31:16] + 16'h1234};
    endfunction

    // Memory model: answers each request after mem_lat cycles.
    always @(negedge clk) begin
        mem_ack = 1'b0;
        mem_err = 1'b0;
        if (rst_n && mem_req && !prev_req) begin
            req_cnt++;
            cap_addr = mem_addr;
        end
        if (rst_n && mem_req) begin
            if (wait_cnt >= mem_lat) begin
                if (mem_fail) mem_err = 1'b1;
                else begin
                    mem_ack   = 1'b1;
                    mem_rdata = mem_val(mem_addr);
                end
            end else wait_cnt++;
        end else wait_cnt = 0;
        prev_req = mem_req;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One 17-bit exchange, MSB first; ser_out read before each strobe.
    task automatic exchange(input logic [FW-1:0] tx, output logic [FW-1:0] rx);
        for (int i = FW - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_in  = tx[i];
            rx[i]   = ser_out;
            bit_stb = 1'b1;
            @(negedge clk);
            bit_stb = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic illegal_cmd(input logic flag, input logic [W-1:0] code);
        logic [FW-1:0] rx;
        int n0;
        n0 = req_cnt;
        exchange({flag, code}, rx);
        check("R2 reply to previous frame", 32'(rx), 32'(exp_tail));
        exp_tail = ILL;
        repeat (4) @(negedge clk);
        check("R4 no request after illegal", 32'(req_cnt), 32'(n0));
        check("R4 mem_req low", 32'(mem_req), 32'd0);
    endtask

    task automatic do_read(input logic [31:0] addr, input int lat, input bit fail, input int rd_pct);
        logic [FW-1:0] rx;
        logic [W-1:0]  fill;
        logic [31:0]   d;
        int n0;
        int nr;
        mem_lat  = lat;
        mem_fail = fail;
        n0 = req_cnt;
        exchange({1'b0, READ}, rx);
        check("R2/R8 previous reply on command frame", 32'(rx), 32'(exp_tail));
        exchange({1'b0, addr[31:16]}, rx);
        check("R3 command answered not-ready", 32'(rx), 32'(NR));
        exchange({1'b0, addr[15:0]}, rx);
        check("R5 high address answered not-ready", 32'(rx), 32'(NR));
        check("R5 one request issued", 32'(req_cnt), 32'(n0 + 1));
        check("R5 request address", cap_addr, addr);
        nr = 0;
        do begin
            fill = ($urandom % 100 < rd_pct) ? READ : W'($urandom);
            exchange({1'($urandom), fill}, rx);
            if (rx == NR) nr++;
        end while (rx == NR && nr < 40);
        check("R5/R7 low address answered not-ready", 32'(nr >= 1), 32'd1);
        check("R7 not-ready count lower bound", 32'(nr >= lat / 90), 32'd1);
        check("R7 not-ready count upper bound", 32'(nr <= lat / 80 + 3), 32'd1);
        d = mem_val(addr);
        if (fail) begin
            check("R9 bus error in upper slot", 32'(rx), 32'(BERR));
            exp_tail = BERR;
        end else begin
            check("R8 upper result word", 32'(rx), 32'({1'b0, d[31:16]}));
            exp_tail = {1'b0, d[15:0]};
        end
        check("R7 single request per read", 32'(req_cnt), 32'(n0 + 1));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        check("R1 mem_req low in reset", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 mem_req low after reset", 32'(mem_req), 32'd0);
        check("R1 first reply bit is command-complete flag", 32'(ser_out), 32'd0);
        exp_tail = CDONE;
        // Directed corners
        illegal_cmd(1'b0, 16'h0000);            // R1 tail, R4
        illegal_cmd(1'b1, READ);                // R4 flag set
        do_read(32'h0000_0000, 0, 1'b0, 0);     // R8 fast
        do_read(32'hFFFF_FFFF, 300, 1'b0, 100); // R7 fillers carry read code
        do_read(32'h1234_5678, 5, 1'b1, 0);     // R9
        illegal_cmd(1'b0, 16'hFFFF);            // R9 tail then R4
        do_read(32'hCAFE_0001, 120, 1'b1, 50);
        // Random mix
        for (int k = 0; k < 25; k++) begin
            if ($urandom % 10 < 2) illegal_cmd(1'($urandom % 2), (16'($urandom) == READ) ? 16'h0001 : 16'($urandom));
            else do_read($urandom, $urandom % 250, ($urandom % 5) == 0, 10);
        end
        illegal_cmd(1'b0, 16'h0BAD);            // flush last tail
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule